// File: doc/BRIEF.md
# Windowed Data and Instruction Address Mapper

This block turns the logical addresses seen by a processor core into physical memory targets. A data request carries a 16-bit address. An instruction request carries an 18-bit byte address. The result names one of three targets: on-chip data memory, on-chip instruction memory, or one segment of a large unified memory that is split into 128 KB segments. The result also gives the physical offset inside that target, the segment number when the target is unified memory, and a bus-error flag.

Three 16-bit map registers steer the translation. The data map controls a 16 KB window in data space, and two instruction maps each cover one half of instruction space. Software writes these registers through a small write port. The translation is combinational by default. A parameter adds one register stage on the outputs.

Top module: `addr_map_xlat`

## Requirements
- R1: A data request (`req_instr`=0) with address 0x0000..0x7FFF gives target data memory (`tgt_sel`=0), offset equal to the address, segment 0, and no bus error.
- R2: A data request with address 0xC000..0xFFFF gives target data memory with offset equal to the address and segment 0. The bus error is raised for every such address except 0xFF00..0xFF0F.
- R3: A data request with address 0x8000..0xBFFF, when data-map bit 12 is set, gives target instruction memory (`tgt_sel`=1), segment 0, offset (data-map bits 3:0)×0x4000 + (address − 0x8000), and no bus error.
- R4: A data request in 0x8000..0xBFFF, when data-map bit 12 is clear, gives target unified memory (`tgt_sel`=2), segment = data-map bits 9:3, offset (data-map bits 2:0)×0x4000 + (address − 0x8000), and no bus error.
- R5: For an instruction request (`req_instr`=1), address bit 17 picks the second instruction map when it is 1 and the first map when it is 0.
- R6: When bit 12 of the picked instruction map is set, the target is instruction memory, the offset is the full 18-bit address, the segment is 0, and there is no bus error.
- R7: When bit 12 of the picked instruction map is clear, the target is unified memory, the segment is map bits 7:0, and the offset is address bits 16:0. A bus error is raised unless the segment is populated. Populated segments are those below `POP_LOW` (default 3) and segment `NUM_SEGS`−1 (default 127).
- R8: After reset the data map is 0x0000, the first instruction map is 0x0000, and the second instruction map is 0x007F.
- R9: A write with `map_wr_en`=1 loads `map_wr_data` into the map picked by `map_wr_sel` (0 data map, 1 first instruction map, 2 second instruction map). The new value steers translation from the next clock edge on. A write with `map_wr_sel`=3 changes no map.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_addr | input | 18 | Logical address; a data access uses bits 15:0 |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_sel | input | 2 | Map register select: 0 data, 1 first instruction map, 2 second instruction map, 3 none |
| map_wr_data | input | 16 | Value to write into the selected map |
| tgt_sel | output | 2 | Target: 0 data memory, 1 instruction memory, 2 unified memory |
| phys_seg | output | 8 | Unified memory segment number (0 for other targets) |
| phys_off | output | 18 | Byte offset inside the target |
| bus_err | output | 1 | Access error flag |

## Verification
The bench sweeps the whole data space under three data-map settings. This catches window-edge mistakes at 0x7FFF/0x8000 and 0xBFFF/0xC000. A design that mixes up the bank and segment fields of the data map would put window hits in the wrong 16 KB bank. A design whose I/O comparison is off by one would flag, or fail to flag, 0xFF0F and 0xFF10. The instruction sweeps cover both halves of instruction space under several map pairs, including unpopulated segments and segments at or above 128. A map-select inversion or a missing 17-bit truncation shows up as a wrong offset or a wrong error flag. Map writes are checked in the cycle before and the cycle after the clock edge, and a write to the unused select value is checked for having no effect.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;

    localparam int DADDR_W = 16;
    localparam int IADDR_W = 18;
    localparam int MAP_W   = 16;
    localparam int SEG_W   = 8;
    localparam int OFF_W   = 18;
    localparam int WIN_W   = 14;
    localparam int UOFF_W  = 17;
    localparam int MAP_DIRECT_BIT = 12;

    typedef enum logic [1:0] {
        TGT_DMEM = 2'd0,
        TGT_IMEM = 2'd1,
        TGT_UMEM = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        SEL_DMAP  = 2'd0,
        SEL_IMAP0 = 2'd1,
        SEL_IMAP1 = 2'd2,
        SEL_NONE  = 2'd3
    } map_sel_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic             err;
    } xlat_t;

    function automatic logic io_ok(input logic [DADDR_W-1:0] a);
        return a[DADDR_W-1:4] == 12'hFF0;
    endfunction

endpackage

// File: rtl/addr_map_regs.sv
module addr_map_regs
    import addr_map_pkg::*;
#(
    parameter logic [MAP_W-1:0] DMAP_RST  = 16'h0000,
    parameter logic [MAP_W-1:0] IMAP0_RST = 16'h0000,
    parameter logic [MAP_W-1:0] IMAP1_RST = 16'h007F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [MAP_W-1:0] wr_data,
    output logic [MAP_W-1:0] dmap,
    output logic [MAP_W-1:0] imap0,
    output logic [MAP_W-1:0] imap1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dmap  <= DMAP_RST;
            imap0 <= IMAP0_RST;
            imap1 <= IMAP1_RST;
        end else if (wr_en) begin
            case (map_sel_e'(wr_sel))
                SEL_DMAP:  dmap  <= wr_data;
                SEL_IMAP0: imap0 <= wr_data;
                SEL_IMAP1: imap1 <= wr_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/addr_map_dxlat.sv
module addr_map_dxlat
    import addr_map_pkg::*;
(
    input  logic [DADDR_W-1:0] addr,
    input  logic [MAP_W-1:0]   dmap,
    output xlat_t              res
);
    logic in_window;
    logic in_io;
    logic unused_dmap;

    assign in_window   = addr[15:14] == 2'b10;
    assign in_io       = addr[15:14] == 2'b11;
    assign unused_dmap = ^{dmap[15:13], dmap[11:10]};

    always_comb begin
        res.tgt = TGT_DMEM;
        res.seg = '0;
        res.off = {{(OFF_W-DADDR_W){1'b0}}, addr};
        res.err = 1'b0;
        if (in_io) begin
            res.err = !io_ok(addr);
        end else if (in_window) begin
            if (dmap[MAP_DIRECT_BIT]) begin
                res.tgt = TGT_IMEM;
                res.off = {dmap[3:0], addr[WIN_W-1:0]};
            end else begin
                res.tgt = TGT_UMEM;
                res.seg = {1'b0, dmap[9:3]};
                res.off = {1'b0, dmap[2:0], addr[WIN_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/addr_map_ixlat.sv
module addr_map_ixlat
    import addr_map_pkg::*;
#(
    parameter int POP_LOW  = 3,
    parameter int NUM_SEGS = 128
) (
    input  logic [IADDR_W-1:0] addr,
    input  logic [MAP_W-1:0]   imap0,
    input  logic [MAP_W-1:0]   imap1,
    output xlat_t              res
);
    logic [MAP_W-1:0] map_pick;
    logic [SEG_W-1:0] seg;
    logic             populated;
    logic             unused_map;

    assign map_pick   = addr[IADDR_W-1] ? imap1 : imap0;
    assign seg        = map_pick[SEG_W-1:0];
    assign populated  = (int'(seg) < POP_LOW) || (int'(seg) == NUM_SEGS - 1);
    assign unused_map = ^{map_pick[15:13], map_pick[11:8]};

    always_comb begin
        if (map_pick[MAP_DIRECT_BIT]) begin
            res.tgt = TGT_IMEM;
            res.seg = '0;
            res.off = addr;
            res.err = 1'b0;
        end else begin
            res.tgt = TGT_UMEM;
            res.seg = seg;
            res.off = {1'b0, addr[UOFF_W-1:0]};
            res.err = !populated;
        end
    end
endmodule

// File: rtl/addr_map_xlat.sv
module addr_map_xlat
    import addr_map_pkg::*;
#(
    parameter int POP_LOW  = 3,
    parameter int NUM_SEGS = 128,
    parameter bit REG_OUT  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_instr,
    input  logic [IADDR_W-1:0] req_addr,
    input  logic               map_wr_en,
    input  logic [1:0]         map_wr_sel,
    input  logic [MAP_W-1:0]   map_wr_data,
    output logic [1:0]         tgt_sel,
    output logic [SEG_W-1:0]   phys_seg,
    output logic [OFF_W-1:0]   phys_off,
    output logic               bus_err
);
    logic [MAP_W-1:0] dmap_q;
    logic [MAP_W-1:0] imap0_q;
    logic [MAP_W-1:0] imap1_q;
    xlat_t            d_res;
    xlat_t            i_res;
    xlat_t            sel_res;
    xlat_t            out_res;

    addr_map_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (map_wr_en),
        .wr_sel  (map_wr_sel),
        .wr_data (map_wr_data),
        .dmap    (dmap_q),
        .imap0   (imap0_q),
        .imap1   (imap1_q)
    );

    addr_map_dxlat u_dxlat (
        .addr (req_addr[DADDR_W-1:0]),
        .dmap (dmap_q),
        .res  (d_res)
    );

    addr_map_ixlat #(
        .POP_LOW  (POP_LOW),
        .NUM_SEGS (NUM_SEGS)
    ) u_ixlat (
        .addr  (req_addr),
        .imap0 (imap0_q),
        .imap1 (imap1_q),
        .res   (i_res)
    );

    assign sel_res = req_instr ? i_res : d_res;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) out_res <= '0;
                else     out_res <= sel_res;
            end
        end else begin : g_comb
            assign out_res = sel_res;
        end
    endgenerate

    assign tgt_sel  = out_res.tgt;
    assign phys_seg = out_res.seg;
    assign phys_off = out_res.off;
    assign bus_err  = out_res.err;
endmodule

// File: rtl/addr_map_chk.sv
module addr_map_chk
    import addr_map_pkg::*;
#(
    parameter int POP_LOW  = 3,
    parameter int NUM_SEGS = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               map_wr_en,
    input logic [1:0]         map_wr_sel,
    input logic [MAP_W-1:0]   map_wr_data,
    input logic [1:0]         tgt_sel,
    input logic [SEG_W-1:0]   phys_seg,
    input logic               bus_err,
    input logic [MAP_W-1:0]   dmap_q,
    input logic [MAP_W-1:0]   imap0_q,
    input logic [MAP_W-1:0]   imap1_q
);
    // R8
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dmap_q == 16'h0000 && imap0_q == 16'h0000 && imap1_q == 16'h007F));

    // R9
    imap0_load_chk: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && map_wr_sel == 2'd1) |=> imap0_q == $past(map_wr_data));

    // R9
    dmap_load_chk: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && map_wr_sel == 2'd0) |=> dmap_q == $past(map_wr_data));

    // R9
    none_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && map_wr_sel == 2'd3) |=>
            ($stable(dmap_q) && $stable(imap0_q) && $stable(imap1_q)));

    // R6
    imem_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_sel == 2'd1 |-> (!bus_err && phys_seg == '0));

    // R7
    umem_err_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_sel == 2'd2 && bus_err) |->
            !(int'(phys_seg) < POP_LOW || int'(phys_seg) == NUM_SEGS - 1));

    // R1
    tgt_code_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_sel != 2'd3);
endmodule

bind addr_map_xlat addr_map_chk #(
    .POP_LOW  (POP_LOW),
    .NUM_SEGS (NUM_SEGS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .map_wr_en   (map_wr_en),
    .map_wr_sel  (map_wr_sel),
    .map_wr_data (map_wr_data),
    .tgt_sel     (tgt_sel),
    .phys_seg    (phys_seg),
    .bus_err     (bus_err),
    .dmap_q      (dmap_q),
    .imap0_q     (imap0_q),
    .imap1_q     (imap1_q)
);

// File: tb/addr_map_xlat_tb.sv
module addr_map_xlat_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_instr = 1'b0;
    logic [17:0] req_addr = '0;
    logic        map_wr_en = 1'b0;
    logic [1:0]  map_wr_sel = '0;
    logic [15:0] map_wr_data = '0;
    logic [1:0]  tgt_sel;
    logic [7:0]  phys_seg;
    logic [17:0] phys_off;
    logic        bus_err;

    int tests = 0;
    int fails = 0;
    logic [15:0] sh_dmap, sh_imap0, sh_imap1;

    always #5 clk = ~clk;

    addr_map_xlat u_dut (
        .clk(clk), .rst(rst), .req_instr(req_instr), .req_addr(req_addr),
        .map_wr_en(map_wr_en), .map_wr_sel(map_wr_sel), .map_wr_data(map_wr_data),
        .tgt_sel(tgt_sel), .phys_seg(phys_seg), .phys_off(phys_off), .bus_err(bus_err)
    );

    // packed expectation: {tgt[1:0], seg[7:0], off[17:0], err}
    function automatic logic [28:0] model(input logic instr, input int a,
                                          input int dm, input int im0, input int im1);
        int tg, sg, of, er, m;
        tg = 0; sg = 0; of = 0; er = 0;
        if (!instr) begin
            a = a % 65536;
            of = a;
            if (a >= 49152) begin
                er = (a >= 65280 && a <= 65295) ? 0 : 1;
            end else if (a >= 32768) begin
                if ((dm / 4096) % 2 == 1) begin
                    tg = 1; of = (dm % 16) * 16384 + (a - 32768);
                end else begin
                    tg = 2; sg = (dm / 8) % 128;
                    of = (dm % 8) * 16384 + (a - 32768);
                end
            end
        end else begin
            m = (a >= 131072) ? im1 : im0;
            if ((m / 4096) % 2 == 1) begin
                tg = 1; of = a;
            end else begin
                tg = 2; sg = m % 256; of = a % 131072;
                er = (sg < 3 || sg == 127) ? 0 : 1;
            end
        end
        return {tg[1:0], sg[7:0], of[17:0], er[0]};
    endfunction

    task automatic check(input string req);
        logic [28:0] e, g;
        e = model(req_instr, int'(req_addr), int'(sh_dmap), int'(sh_imap0), int'(sh_imap1));
        g = {tgt_sel, phys_seg, phys_off, bus_err};
        tests++;
        if (g !== e) begin
            fails++;
            if (fails < 25)
                $display("FAIL %s instr=%0d addr=%h got=%h exp=%h", req, req_instr, req_addr, g, e);
        end
    endtask

    task automatic wr_map(input logic [1:0] s, input logic [15:0] v);
        map_wr_en = 1'b1; map_wr_sel = s; map_wr_data = v;
        @(posedge clk); #5;
        map_wr_en = 1'b0;
        case (s)
            2'd0: sh_dmap = v;
            2'd1: sh_imap0 = v;
            2'd2: sh_imap1 = v;
            default: ;
        endcase
    endtask

    task automatic data_sweep();
        for (int a = 0; a < 65536; a++) begin
            req_instr = 1'b0; req_addr = 18'(a); #1;
            if (a < 32768) check("R1");
            else if (a >= 49152) check("R2");
            else if (sh_dmap[12]) check("R3");
            else check("R4");
        end
    endtask

    task automatic instr_sweep();
        for (int a = 0; a < 262144; a += 37) begin
            req_instr = 1'b1; req_addr = 18'(a); #1;
            if ((a >= 131072 ? sh_imap1[12] : sh_imap0[12])) check("R6");
            else check("R7");
        end
        req_addr = 18'h1FFFF; #1; check("R5");
        req_addr = 18'h20000; #1; check("R5");
        req_addr = 18'h3FFFF; #1; check("R5");
    endtask

    initial begin
        sh_dmap = 16'h0000; sh_imap0 = 16'h0000; sh_imap1 = 16'h007F;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        @(posedge clk); #5;
        // R8: reset map values observed through translation
        req_instr = 1'b0; req_addr = 18'h0A123; #1; check("R8");
        req_instr = 1'b1; req_addr = 18'h2ABCD; #1; check("R8");
        req_addr = 18'h0ABCD; #1; check("R8");
        data_sweep();
        instr_sweep();

        // R9: new value not visible before the edge, visible after
        req_instr = 1'b0; req_addr = 18'h09ABC;
        map_wr_en = 1'b1; map_wr_sel = 2'd0; map_wr_data = 16'h1005; #1;
        check("R9");
        @(posedge clk); #5; map_wr_en = 1'b0; sh_dmap = 16'h1005;
        check("R9");
        data_sweep();
        wr_map(2'd0, 16'h02AB);
        data_sweep();
        wr_map(2'd0, 16'hEFFF);
        data_sweep();

        // R9: select 3 leaves all maps untouched
        wr_map(2'd3, 16'h1234);
        req_instr = 1'b0; req_addr = 18'h08000; #1; check("R9");
        req_instr = 1'b1; req_addr = 18'h00040; #1; check("R9");
        req_addr = 18'h20040; #1; check("R9");

        wr_map(2'd1, 16'h1000);
        wr_map(2'd2, 16'h0002);
        instr_sweep();
        wr_map(2'd1, 16'h0003);
        wr_map(2'd2, 16'h00FF);
        instr_sweep();
        wr_map(2'd1, 16'h0080);
        wr_map(2'd2, 16'hF07F);
        instr_sweep();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        tests++; fails++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule